// File: doc/BRIEF.md
# Chain Sideband Reset and Interrupt Controller

This block sits in each chip of a linear chain of accelerators and drives the low-speed signals shared with the two neighbouring chips. The left side faces upstream, toward the host. The right side faces downstream, toward the next chip. Cold reset travels downstream. Warm reset and boot-complete indications travel upstream. Level interrupts cross in both directions, each guarded by a four-phase request/acknowledge handshake. A non-maskable interrupt line is also driven toward the chain.

A two-bit chain-position input, taken from configuration straps, selects which sides are live. A flow-control strap lends the interrupt pins to another function; while it is set, both interrupt handshakes are shut off. Before any neighbour input is used, it passes through a multi-flop synchronizer.

Top module: `chain_sideband_ctrl`

## Requirements
- R1: `r_cold_rst_n_o` is low while `rst_n` is low, and it stays low for `RST_HOLD` rising edges after `rst_n` is released. It goes high on rising edge `RST_HOLD`+1.
- R2: Every neighbour input passes through a `SYNC_STAGES` (default 2) flop synchronizer. A change on `r_wrst_n_i` reaches `l_wrst_n_o` on the third rising edge after it is applied, and not before.
- R3: `l_wrst_n_o` is low in the cycle after either of two causes, and high otherwise:
  - `wdt_evt_i` is high while the left side is live, or
  - the synchronized `r_wrst_n_i` is low while the right side is live.
- R4: `l_boot_o` is high when all of the following hold, and is low the cycle after `boot_done_i` drops:
  - `boot_done_i` is high, and
  - the left side is live, and
  - either the synchronized `r_boot_i` is high on a live right side, or the chip is last in the chain.
- R5: Each interrupt output runs a four-phase handshake, started by `irq_send_i` (bit 0 left, bit 1 right):
  - the request is raised only while the acknowledge is low;
  - the request is held until the synchronized acknowledge is seen high, then dropped;
  - no new request starts until the acknowledge has been seen low.
- R6: On each side, the acknowledge output follows the synchronized interrupt input. The matching `irq_rcv_o` bit pulses for exactly one cycle per request, on the edge where the acknowledge rises.
- R7: `pos_i` is encoded as follows:
  - 0 is single chip; neither side is live, the left outputs stay inactive and `nmi_o` stays low;
  - 1 is first chip; both sides are live;
  - 2 is middle chip; both sides are live;
  - 3 is last chip; only the left side is live, and all right-side inputs are ignored.
- R8: While `fc_mode_i` is high, every interrupt request and acknowledge output is low and no `irq_rcv_o` pulse occurs. Reset and boot signalling are unaffected.
- R9: `nmi_o` follows `nmi_req_i` one cycle later whenever the chip is not single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Local reset, active low, asynchronous assert |
| pos_i | input | 2 | Chain position strap (0 single, 1 first, 2 middle, 3 last) |
| fc_mode_i | input | 1 | Pins lent to flow control; disables interrupt handshakes |
| wdt_evt_i | input | 1 | Local watchdog expiry, active high |
| boot_done_i | input | 1 | Local boot finished |
| nmi_req_i | input | 1 | Local non-maskable interrupt request |
| irq_send_i | input | 2 | Local interrupt send request per side (0 left, 1 right) |
| irq_rcv_o | output | 2 | One-cycle pulse per interrupt received per side |
| r_cold_rst_n_o | output | 1 | Cold reset to downstream chip, active low |
| r_wrst_n_i | input | 1 | Warm reset from downstream chip, active low |
| r_boot_i | input | 1 | Boot complete from downstream chip |
| r_irq_i | input | 1 | Interrupt request from downstream chip |
| r_irq_ack_o | output | 1 | Acknowledge to downstream interrupt request |
| r_irq_o | output | 1 | Interrupt request to downstream chip |
| r_irq_ack_i | input | 1 | Acknowledge from downstream chip |
| l_wrst_n_o | output | 1 | Warm reset to upstream chip, active low |
| l_boot_o | output | 1 | Boot complete to upstream chip |
| l_irq_i | input | 1 | Interrupt request from upstream chip |
| l_irq_ack_o | output | 1 | Acknowledge to upstream interrupt request |
| l_irq_o | output | 1 | Interrupt request to upstream chip |
| l_irq_ack_i | input | 1 | Acknowledge from upstream chip |
| nmi_o | output | 1 | Non-maskable interrupt toward the chain |

## Verification
The embedded properties watch several rules on every cycle:
- a request is never raised while the acknowledge is high, and never dropped before it;
- a receive pulse never lasts two cycles;
- a disabled side never acknowledges;
- boot-complete never leads the local boot flag;
- a watchdog event always pulls the upstream warm reset;
- a single-chip position keeps the left outputs quiet.

Only the directed scenarios show the things that need counted cycles or input sequences. These are the exact cold-reset stretch length, the three-edge synchronizer latency, the re-arm of a held request after the acknowledge falls, and the ignoring of right-side pins on the last chip.

// File: rtl/chain_sb_pkg.sv
`timescale 1ns/1ps
package chain_sb_pkg;
   typedef enum logic [1:0] {
      POS_SOLO = 2'd0,
      POS_HEAD = 2'd1,
      POS_MID  = 2'd2,
      POS_TAIL = 2'd3
   } chain_pos_e;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_REQ  = 2'd1,
      TX_DROP = 2'd2
   } irq_tx_e;

   localparam int SIDE_L = 0;
   localparam int SIDE_R = 1;
   localparam int NSIDES = 2;

   function automatic logic left_live(chain_pos_e p);
      return p != POS_SOLO;
   endfunction

   function automatic logic right_live(chain_pos_e p);
      return (p == POS_HEAD) || (p == POS_MID);
   endfunction
endpackage

// File: rtl/sb_sync.sv
`timescale 1ns/1ps
module sb_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("sb_sync: STAGES must be 2..4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sb_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cold_rst_stretch.sv
`timescale 1ns/1ps
module cold_rst_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic cold_n_o
);
   localparam int CW = $clog2(HOLD + 2);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

   if (HOLD < 0) begin : g_bad_hold
      $error("cold_rst_stretch: HOLD must not be negative");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= HOLD_V;
         cold_n_o <= 1'b0;
      end else begin
         if (cnt != '0) cnt <= cnt - 1'b1;
         cold_n_o <= (cnt == '0);
      end
   end
endmodule

// File: rtl/irq_tx_hs.sv
`timescale 1ns/1ps
module irq_tx_hs
   import chain_sb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic send_i,
   input  logic ack_i,
   output logic req_o
);
   irq_tx_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         req_o <= 1'b0;
      end else if (!en_i) begin
         st    <= TX_IDLE;
         req_o <= 1'b0;
      end else begin
         unique case (st)
            TX_IDLE: if (send_i && !ack_i) begin
               st    <= TX_REQ;
               req_o <= 1'b1;
            end
            TX_REQ: if (ack_i) begin
               st    <= TX_DROP;
               req_o <= 1'b0;
            end
            TX_DROP: if (!ack_i) st <= TX_IDLE;
            default: begin
               st    <= TX_IDLE;
               req_o <= 1'b0;
            end
         endcase
      end
   end

   AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i && en_i) |=> req_o); // R5
   AST_NO_REQ_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_o && ack_i) |=> !req_o); // R5
endmodule

// File: rtl/irq_rx_hs.sv
`timescale 1ns/1ps
module irq_rx_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic req_i,
   output logic ack_o,
   output logic hit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o <= 1'b0;
         hit_o <= 1'b0;
      end else begin
         ack_o <= en_i & req_i;
         hit_o <= en_i & req_i & ~ack_o;
      end
   end

   AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!ack_o && !hit_o)); // R8
   AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o); // R6
endmodule

// File: rtl/chain_sideband_ctrl.sv
`timescale 1ns/1ps
module chain_sideband_ctrl
   import chain_sb_pkg::*;
#(
   parameter int RST_HOLD = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pos_i,
   input  logic       fc_mode_i,
   input  logic       wdt_evt_i,
   input  logic       boot_done_i,
   input  logic       nmi_req_i,
   input  logic [1:0] irq_send_i,
   output logic [1:0] irq_rcv_o,
   output logic       r_cold_rst_n_o,
   input  logic       r_wrst_n_i,
   input  logic       r_boot_i,
   input  logic       r_irq_i,
   output logic       r_irq_ack_o,
   output logic       r_irq_o,
   input  logic       r_irq_ack_i,
   output logic       l_wrst_n_o,
   output logic       l_boot_o,
   input  logic       l_irq_i,
   output logic       l_irq_ack_o,
   output logic       l_irq_o,
   input  logic       l_irq_ack_i,
   output logic       nmi_o
);
   localparam int NSYNC = 6;
   // bit order: {r_wrst_n, r_boot, r_irq, r_ack, l_irq, l_ack}
   localparam logic [NSYNC-1:0] SYNC_RST = 6'b100000;

   chain_pos_e pos;
   logic       l_act, r_act;
   logic [NSIDES-1:0] hs_en;

   assign pos   = chain_pos_e'(pos_i);
   assign l_act = left_live(pos);
   assign r_act = right_live(pos);
   assign hs_en[SIDE_L] = l_act & ~fc_mode_i;
   assign hs_en[SIDE_R] = r_act & ~fc_mode_i;

   logic [NSYNC-1:0] raw_in, syn;
   assign raw_in = {r_wrst_n_i, r_boot_i, r_irq_i, r_irq_ack_i, l_irq_i, l_irq_ack_i};

   sb_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
   );

   logic s_wrst_n, s_boot;
   logic [NSIDES-1:0] s_req, s_ack;
   assign s_wrst_n      = syn[5] | ~r_act;
   assign s_boot        = syn[4] &  r_act;
   assign s_req[SIDE_R] = syn[3];
   assign s_ack[SIDE_R] = syn[2];
   assign s_req[SIDE_L] = syn[1];
   assign s_ack[SIDE_L] = syn[0];

   cold_rst_stretch #(.HOLD(RST_HOLD)) i_cold (
      .clk(clk), .rst_n(rst_n), .cold_n_o(r_cold_rst_n_o)
   );

   logic down_ok;
   assign down_ok = r_act ? s_boot : (pos == POS_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_wrst_n_o <= 1'b1;
         l_boot_o   <= 1'b0;
         nmi_o      <= 1'b0;
      end else begin
         l_wrst_n_o <= ~(l_act & (wdt_evt_i | ~s_wrst_n));
         l_boot_o   <= l_act & boot_done_i & down_ok;
         nmi_o      <= l_act & nmi_req_i;
      end
   end

   logic [NSIDES-1:0] req_out, ack_out;

   for (genvar s = 0; s < NSIDES; s++) begin : g_side
      irq_tx_hs i_tx (
         .clk(clk), .rst_n(rst_n), .en_i(hs_en[s]), .send_i(irq_send_i[s]),
         .ack_i(s_ack[s]), .req_o(req_out[s])
      );
      irq_rx_hs i_rx (
         .clk(clk), .rst_n(rst_n), .en_i(hs_en[s]), .req_i(s_req[s]),
         .ack_o(ack_out[s]), .hit_o(irq_rcv_o[s])
      );
   end

   assign l_irq_o     = req_out[SIDE_L];
   assign r_irq_o     = req_out[SIDE_R];
   assign l_irq_ack_o = ack_out[SIDE_L];
   assign r_irq_ack_o = ack_out[SIDE_R];

   AST_BOOT_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_done_i |=> !l_boot_o); // R4
   AST_WDT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_evt_i && l_act) |=> !l_wrst_n_o); // R3
   AST_SOLO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_i == 2'd0) |=> (!l_boot_o && l_wrst_n_o && !nmi_o)); // R7
   AST_FC_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      fc_mode_i |=> (!l_irq_o && !r_irq_o && !l_irq_ack_o && !r_irq_ack_o)); // R8
endmodule

// File: tb/test_chain_sideband_ctrl.sv
`timescale 1ns/1ps
module test_chain_sideband_ctrl;
   localparam int HOLD = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic [1:0] pos_i;
   logic fc_mode_i, wdt_evt_i, boot_done_i, nmi_req_i;
   logic [1:0] irq_send_i;
   logic [1:0] irq_rcv_o;
   logic r_cold_rst_n_o, r_wrst_n_i, r_boot_i, r_irq_i, r_irq_ack_o, r_irq_o, r_irq_ack_i;
   logic l_wrst_n_o, l_boot_o, l_irq_i, l_irq_ack_o, l_irq_o, l_irq_ack_i, nmi_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   chain_sideband_ctrl #(.RST_HOLD(HOLD), .SYNC_STAGES(2)) i_chain_sideband_ctrl (
      .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .fc_mode_i(fc_mode_i),
      .wdt_evt_i(wdt_evt_i), .boot_done_i(boot_done_i), .nmi_req_i(nmi_req_i),
      .irq_send_i(irq_send_i), .irq_rcv_o(irq_rcv_o),
      .r_cold_rst_n_o(r_cold_rst_n_o), .r_wrst_n_i(r_wrst_n_i), .r_boot_i(r_boot_i),
      .r_irq_i(r_irq_i), .r_irq_ack_o(r_irq_ack_o), .r_irq_o(r_irq_o),
      .r_irq_ack_i(r_irq_ack_i), .l_wrst_n_o(l_wrst_n_o), .l_boot_o(l_boot_o),
      .l_irq_i(l_irq_i), .l_irq_ack_o(l_irq_ack_o), .l_irq_o(l_irq_o),
      .l_irq_ack_i(l_irq_ack_i), .nmi_o(nmi_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic idle_inputs();
      fc_mode_i = 1'b0; wdt_evt_i = 1'b0; boot_done_i = 1'b0; nmi_req_i = 1'b0;
      irq_send_i = 2'b00; r_wrst_n_i = 1'b1; r_boot_i = 1'b0; r_irq_i = 1'b0;
      r_irq_ack_i = 1'b0; l_irq_i = 1'b0; l_irq_ack_i = 1'b0;
   endtask

   task automatic t_reset();
      pos_i = 2'd2;
      idle_inputs();
      rst_n = 1'b0;
      step(3);
      chk("R1 cold low in reset", r_cold_rst_n_o, 0);
      chk("R3 warm idle in reset", l_wrst_n_o, 1);
      chk("R4 boot low in reset", l_boot_o, 0);
      chk("R5 irq outs low in reset", {l_irq_o, r_irq_o}, 0);
      chk("R6 acks low in reset", {l_irq_ack_o, r_irq_ack_o}, 0);
      rst_n = 1'b1;
      step(HOLD);
      chk("R1 cold still low at HOLD", r_cold_rst_n_o, 0);
      step(1);
      chk("R1 cold released at HOLD+1", r_cold_rst_n_o, 1);
      step(4);
      rst_n = 1'b0;
      #1;
      chk("R1 cold low on reassert", r_cold_rst_n_o, 0);
      step(2);
      rst_n = 1'b1;
      step(HOLD + 2);
      chk("R1 cold high after second release", r_cold_rst_n_o, 1);
   endtask

   task automatic t_sync();
      pos_i = 2'd2; idle_inputs(); step(4);
      r_wrst_n_i = 1'b0;
      step(2);
      chk("R2 not yet at edge 2", l_wrst_n_o, 1);
      step(1);
      chk("R2 visible at edge 3", l_wrst_n_o, 0);
      r_wrst_n_i = 1'b1;
      step(3);
      chk("R2 release after 3 edges", l_wrst_n_o, 1);
   endtask

   task automatic t_warm();
      pos_i = 2'd1; idle_inputs(); step(4);
      wdt_evt_i = 1'b1;
      step(1);
      chk("R3 watchdog pulls warm reset", l_wrst_n_o, 0);
      wdt_evt_i = 1'b0;
      step(1);
      chk("R3 warm reset clears", l_wrst_n_o, 1);
      r_wrst_n_i = 1'b0;
      step(4);
      chk("R3 downstream warm forwarded", l_wrst_n_o, 0);
      r_wrst_n_i = 1'b1;
      step(4);
   endtask

   task automatic t_boot();
      pos_i = 2'd2; idle_inputs(); step(4);
      boot_done_i = 1'b1;
      step(5);
      chk("R4 waits for downstream", l_boot_o, 0);
      r_boot_i = 1'b1;
      step(4);
      chk("R4 reported when both done", l_boot_o, 1);
      boot_done_i = 1'b0;
      step(1);
      chk("R4 drops with local flag", l_boot_o, 0);
      pos_i = 2'd3; boot_done_i = 1'b1; r_boot_i = 1'b0;
      step(2);
      chk("R4 last chip needs only local", l_boot_o, 1);
      idle_inputs(); step(4);
   endtask

   task automatic t_irq_out();
      pos_i = 2'd2; idle_inputs(); step(4);
      irq_send_i[1] = 1'b1;
      step(1);
      chk("R5 right request raised", r_irq_o, 1);
      step(6);
      chk("R5 request held without ack", r_irq_o, 1);
      r_irq_ack_i = 1'b1;
      step(2);
      chk("R5 request held until ack synced", r_irq_o, 1);
      step(1);
      chk("R5 request dropped after ack", r_irq_o, 0);
      step(6);
      chk("R5 no new request while ack high", r_irq_o, 0);
      r_irq_ack_i = 1'b0;
      step(3);
      chk("R5 still idle before ack fall seen", r_irq_o, 0);
      step(1);
      chk("R5 next request after ack fall", r_irq_o, 1);
      irq_send_i[1] = 1'b0;
      r_irq_ack_i = 1'b1; step(4);
      r_irq_ack_i = 1'b0; step(4);
      chk("R5 right idle after handshake", r_irq_o, 0);
      irq_send_i[0] = 1'b1;
      step(1);
      chk("R5 left request raised", l_irq_o, 1);
      irq_send_i[0] = 1'b0;
      l_irq_ack_i = 1'b1; step(4);
      chk("R5 left request dropped", l_irq_o, 0);
      l_irq_ack_i = 1'b0; step(4);
   endtask

   task automatic t_irq_in();
      pos_i = 2'd2; idle_inputs(); step(4);
      r_irq_i = 1'b1;
      step(2);
      chk("R6 ack not before sync", r_irq_ack_o, 0);
      step(1);
      chk("R6 right ack raised", r_irq_ack_o, 1);
      chk("R6 receive pulse", irq_rcv_o[1], 1);
      step(1);
      chk("R6 pulse lasts one cycle", irq_rcv_o[1], 0);
      chk("R6 ack held", r_irq_ack_o, 1);
      r_irq_i = 1'b0;
      step(3);
      chk("R6 ack follows request down", r_irq_ack_o, 0);
      l_irq_i = 1'b1;
      step(3);
      chk("R6 left ack raised", l_irq_ack_o, 1);
      l_irq_i = 1'b0;
      step(4);
   endtask

   task automatic t_position();
      pos_i = 2'd3; idle_inputs(); step(4);
      r_irq_i = 1'b1; r_wrst_n_i = 1'b0;
      step(5);
      chk("R7 last ignores right irq", r_irq_ack_o, 0);
      chk("R7 last ignores right warm", l_wrst_n_o, 1);
      irq_send_i[1] = 1'b1;
      step(3);
      chk("R7 last sends nothing right", r_irq_o, 0);
      l_irq_i = 1'b1;
      step(3);
      chk("R7 last keeps left side", l_irq_ack_o, 1);
      idle_inputs(); step(4);
      pos_i = 2'd0;
      l_irq_i = 1'b1; boot_done_i = 1'b1; nmi_req_i = 1'b1; wdt_evt_i = 1'b1;
      step(5);
      chk("R7 single ignores left irq", l_irq_ack_o, 0);
      chk("R7 single boot quiet", l_boot_o, 0);
      chk("R7 single warm quiet", l_wrst_n_o, 1);
      chk("R7 single nmi quiet", nmi_o, 0);
      idle_inputs(); step(4);
   endtask

   task automatic t_fc();
      pos_i = 2'd2; idle_inputs(); step(4);
      fc_mode_i = 1'b1;
      r_irq_i = 1'b1; l_irq_i = 1'b1; irq_send_i = 2'b11;
      boot_done_i = 1'b1; r_boot_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         if (irq_rcv_o != 2'b00) chk("R8 no receive pulse in flow-control", irq_rcv_o, 0);
      end
      chk("R8 acks off", {l_irq_ack_o, r_irq_ack_o}, 0);
      chk("R8 requests off", {l_irq_o, r_irq_o}, 0);
      chk("R8 boot unaffected", l_boot_o, 1);
      idle_inputs(); step(4);
   endtask

   task automatic t_nmi();
      pos_i = 2'd1; idle_inputs(); step(4);
      nmi_req_i = 1'b1;
      step(1);
      chk("R9 nmi follows", nmi_o, 1);
      nmi_req_i = 1'b0;
      step(1);
      chk("R9 nmi clears", nmi_o, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      pos_i = 2'd2;
      idle_inputs();
      step(1);
      t_reset();
      t_sync();
      t_warm();
      t_boot();
      t_irq_out();
      t_irq_in();
      t_position();
      t_fc();
      t_nmi();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule